// File: doc/BRIEF.md
# Colour Sensor Polling Sequencer

This block drives a colour light-to-digital sensor on an I2C bus through a separate byte-level I2C master, and keeps the latest clear, red, green and blue counts on four parallel outputs. The master has a simple command port. The block raises an enable and presents the device address, a direction bit and a write byte. The master reports each finished byte by dropping its busy flag, and it hands back read bytes on a data input. The bit timing on the wires belongs to the master.

After reset the block waits for the sensor to power up. It then programs the analog gain, the integration time and the power/ADC enable. From then on it loops without end: it pauses for one minimum integration period, reads all eight result bytes in one auto-incrementing burst, and latches them onto the outputs. A parameter gives the system clock rate, and every wait is derived from it. Two more parameters fix the gain and the integration count.

Top module: `color_poll_seq`

## Requirements
- R1: After reset is released, `i2c_ena` stays low for exactly CLK_HZ/10 clock cycles (100 ms) and rises on the cycle after that.
- R2: Initialisation is three write transactions to device address 0x29, each a command byte then a data byte, in this order: command 0x8F (gain register), then command 0x81 (integration register), then command 0x80 with data 0x03 (bit 0 power-on, bit 1 ADC enable).
- R3: The gain data byte carries the code in bits 1:0: GAIN of 1, 4, 16 or 60 gives 0x00, 0x01, 0x02 or 0x03. Any other GAIN value gives 0x00.
- R4: The integration data byte is the 8-bit ATIME parameter, sent unchanged.
- R5: Each poll is one transaction to address 0x29: one write byte 0xB4 (command bit 7, auto-increment type 01 in bits 6:5, start index 0x14), then eight read bytes with `i2c_rw` high.
- R6: The eight read bytes arrive low byte first, in the order clear, red, green, blue. Each output is {second byte, first byte} of its pair, and all four outputs update together 2 cycles after busy falls on the eighth read byte.
- R7: The four data outputs hold their values at every other time.
- R8: After every output update, and after the last initialisation write, the block waits CLK_HZ*24/10000 cycles (2.4 ms) before it raises `i2c_ena` for the next read.
- R9: `ack_err` follows `i2c_ack_error` one cycle later.
- R10: An active-low asynchronous reset at once clears the four outputs, `ack_err` and `i2c_ena`. After release the sequence restarts from the power-up wait of R1.
- R11: The block advances to the next byte only when busy falls, and it drops `i2c_ena` on the cycle after busy falls on the last byte of each transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i2c_busy | input | 1 | Master busy; a falling edge marks a finished byte |
| i2c_rdata | input | 8 | Byte read by the master |
| i2c_ack_error | input | 1 | Acknowledge error reported by the master |
| i2c_ena | output | 1 | Keeps the master's current transaction going |
| i2c_addr | output | 7 | 7-bit device address (0x29) |
| i2c_rw | output | 1 | Direction of the next byte, 1 = read |
| i2c_wdata | output | 8 | Next byte to write |
| ack_err | output | 1 | Registered acknowledge error |
| clear_cnt | output | 16 | Latest clear channel count |
| red_cnt | output | 16 | Latest red channel count |
| green_cnt | output | 16 | Latest green channel count |
| blue_cnt | output | 16 | Latest blue channel count |

## Verification
Each result has a fixed due cycle that the bench counts from its cause. The first `i2c_ena` rise comes exactly CLK_HZ/10 edges after reset release. The next read starts exactly CLK_HZ*24/10000 edges after an output update. The outputs must still show their old values 1 cycle after busy falls on the eighth read byte and the new values 2 cycles after it. `ack_err` must follow the master flag one cycle later. The bench samples on falling edges and counts edges from each triggering event, so every check lands on the exact cycle the requirement names, not inside a window. A master model plays the bus. Every byte it completes is compared in order against a queue of expected bytes, which the driver tasks fill from the parameters and a known read-data pattern.

// File: rtl/color_poll_seq.sv
module color_poll_seq #(
  parameter int          CLK_HZ = 50_000_000,
  parameter int          GAIN   = 1,
  parameter logic [7:0]  ATIME  = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        i2c_busy,
  input  logic [7:0]  i2c_rdata,
  input  logic        i2c_ack_error,
  output logic        i2c_ena,
  output logic [6:0]  i2c_addr,
  output logic        i2c_rw,
  output logic [7:0]  i2c_wdata,
  output logic        ack_err,
  output logic [15:0] clear_cnt,
  output logic [15:0] red_cnt,
  output logic [15:0] green_cnt,
  output logic [15:0] blue_cnt
);
  localparam longint     UP_CYC    = longint'(CLK_HZ) / 10;
  localparam longint     PAUSE_CYC = longint'(CLK_HZ) * 24 / 10000;
  localparam int         CW        = $clog2(UP_CYC + 1);
  localparam logic [1:0] GCODE     = (GAIN == 4)  ? 2'd1 :
                                     (GAIN == 16) ? 2'd2 :
                                     (GAIN == 60) ? 2'd3 : 2'd0;
  localparam logic [7:0] BURST_CMD = 8'hB4;

  typedef enum logic [2:0] {S_UP, S_WR, S_GAP, S_PAUSE, S_RD, S_OUT} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [1:0]  widx;
  logic [3:0]  bidx;
  logic        busy_q;
  logic [63:0] sh;
  logic [7:0]  wr_cmd, wr_val;

  wire byte_done = busy_q & ~i2c_busy;
  assign i2c_addr = 7'h29;

  always_comb begin
    case (widx)
      2'd0:    begin wr_cmd = 8'h8F; wr_val = {6'b0, GCODE}; end
      2'd1:    begin wr_cmd = 8'h81; wr_val = ATIME;         end
      default: begin wr_cmd = 8'h80; wr_val = 8'h03;         end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_UP;
      cnt       <= '0;
      widx      <= '0;
      bidx      <= '0;
      busy_q    <= 1'b0;
      sh        <= '0;
      i2c_ena   <= 1'b0;
      i2c_rw    <= 1'b0;
      i2c_wdata <= '0;
      ack_err   <= 1'b0;
      clear_cnt <= '0;
      red_cnt   <= '0;
      green_cnt <= '0;
      blue_cnt  <= '0;
    end else begin
      busy_q  <= i2c_busy;
      ack_err <= i2c_ack_error;
      case (st)
        S_UP:
          if (cnt == CW'(UP_CYC - 1)) begin
            st        <= S_WR;
            i2c_ena   <= 1'b1;
            i2c_rw    <= 1'b0;
            i2c_wdata <= wr_cmd;
            bidx      <= '0;
          end else cnt <= cnt + 1'b1;
        S_WR:
          if (byte_done) begin
            if (bidx == 4'd0) begin
              i2c_wdata <= wr_val;
              bidx      <= 4'd1;
            end else begin
              i2c_ena <= 1'b0;
              bidx    <= '0;
              cnt     <= '0;
              if (widx == 2'd2) st <= S_PAUSE;
              else begin
                widx <= widx + 1'b1;
                st   <= S_GAP;
              end
            end
          end
        S_GAP:
          if (cnt == CW'(3)) begin
            st        <= S_WR;
            i2c_ena   <= 1'b1;
            i2c_wdata <= wr_cmd;
          end else cnt <= cnt + 1'b1;
        S_PAUSE:
          if (cnt == CW'(PAUSE_CYC - 1)) begin
            st        <= S_RD;
            i2c_ena   <= 1'b1;
            i2c_rw    <= 1'b0;
            i2c_wdata <= BURST_CMD;
            bidx      <= '0;
          end else cnt <= cnt + 1'b1;
        S_RD:
          if (byte_done) begin
            if (bidx == 4'd0) begin
              i2c_rw <= 1'b1;
              bidx   <= 4'd1;
            end else begin
              sh <= {i2c_rdata, sh[63:8]};
              if (bidx == 4'd8) begin
                i2c_ena <= 1'b0;
                bidx    <= '0;
                st      <= S_OUT;
              end else bidx <= bidx + 1'b1;
            end
          end
        S_OUT: begin
          clear_cnt <= sh[15:0];
          red_cnt   <= sh[31:16];
          green_cnt <= sh[47:32];
          blue_cnt  <= sh[63:48];
          cnt       <= '0;
          st        <= S_PAUSE;
        end
        default: st <= S_UP;
      endcase
    end
  end
endmodule

// File: rtl/color_poll_chk.sv
module color_poll_chk #(
  parameter int CLK_HZ = 50_000_000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        i2c_busy,
  input logic        i2c_ack_error,
  input logic        i2c_ena,
  input logic        i2c_rw,
  input logic        ack_err,
  input logic [15:0] clear_cnt,
  input logic [15:0] red_cnt,
  input logic [15:0] green_cnt,
  input logic [15:0] blue_cnt
);
  localparam longint UP_CYC = longint'(CLK_HZ) / 10;

  logic [31:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst < 32'(UP_CYC)) since_rst <= since_rst + 1'b1;
  end

  a_r1_silent_powerup: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_ena |-> since_rst >= 32'(UP_CYC));

  a_r9_ack_set: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_ack_error |=> ack_err);

  a_r9_ack_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !i2c_ack_error |=> !ack_err);

  a_r11_ena_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(i2c_ena) |-> (!$past(i2c_busy) && $past(i2c_busy, 2)));

  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({clear_cnt, red_cnt, green_cnt, blue_cnt}) |->
      ($past(i2c_rw) && !$past(i2c_busy, 2) && $past(i2c_busy, 3)));
endmodule

bind color_poll_seq color_poll_chk #(.CLK_HZ(CLK_HZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .i2c_busy(i2c_busy), .i2c_ack_error(i2c_ack_error),
  .i2c_ena(i2c_ena), .i2c_rw(i2c_rw), .ack_err(ack_err),
  .clear_cnt(clear_cnt), .red_cnt(red_cnt), .green_cnt(green_cnt), .blue_cnt(blue_cnt)
);

// File: tb/tb_color_poll_seq.sv
module tb_i2c_model (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ena,
  input  logic [6:0] addr,
  input  logic       rw,
  input  logic [7:0] wdata,
  input  logic       nack,
  output logic       busy,
  output logic [7:0] rdata,
  output logic       ack_error,
  output logic       evt,
  output logic       evt_rw,
  output logic [7:0] evt_data,
  output logic [6:0] evt_addr
);
  function automatic logic [7:0] pat(int n);
    return 8'(n * 37 + 5);
  endfunction

  logic [1:0] ph;
  logic [3:0] cnt;
  logic       l_rw;
  logic [7:0] l_d;
  logic [6:0] l_a;
  int         rdn;

  assign ack_error = nack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 0; cnt <= 0; busy <= 0; evt <= 0; rdn <= 0; rdata <= 0;
      evt_rw <= 0; evt_data <= 0; evt_addr <= 0; l_rw <= 0; l_d <= 0; l_a <= 0;
    end else begin
      evt <= 1'b0;
      case (ph)
        2'd0: if (ena) begin
          l_rw <= rw; l_d <= wdata; l_a <= addr; busy <= 1'b1; cnt <= 0; ph <= 2'd1;
        end
        2'd1: if (cnt == 4'd5) begin
          busy <= 1'b0; evt <= 1'b1; evt_rw <= l_rw; evt_addr <= l_a;
          if (l_rw) begin
            rdata <= pat(rdn); evt_data <= pat(rdn); rdn <= rdn + 1;
          end else evt_data <= l_d;
          cnt <= 0; ph <= 2'd2;
        end else cnt <= cnt + 1'b1;
        default: if (cnt == 4'd2) begin
          if (ena) begin
            l_rw <= rw; l_d <= wdata; l_a <= addr; busy <= 1'b1; ph <= 2'd1;
          end else ph <= 2'd0;
          cnt <= 0;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end
endmodule

module tb_color_poll_seq;
  localparam int HZ    = 500_000;
  localparam int UP    = HZ / 10;
  localparam int PAUSE = HZ * 24 / 10000;

  typedef struct {bit rw; logic [7:0] d; string tag;} ev_t;

  logic clk = 0, rst_n = 0, nack = 0;
  always #2 clk = ~clk;

  logic busy, ack_e, ena, rw, ack_err, evt, evt_rw;
  logic [7:0] rdata, wdata, evt_data;
  logic [6:0] addr, evt_addr;
  logic [15:0] c_o, r_o, g_o, b_o;

  logic busy_b, ack_b, ena_b, rw_b, ackerr_b, evt_b, evt_rw_b;
  logic [7:0] rdata_b, wdata_b, evt_data_b;
  logic [6:0] addr_b, evt_addr_b;
  logic [15:0] c_b, r_b, g_b, b_b;

  color_poll_seq #(.CLK_HZ(HZ), .GAIN(16), .ATIME(8'hC0)) dut (
    .clk(clk), .rst_n(rst_n), .i2c_busy(busy), .i2c_rdata(rdata), .i2c_ack_error(ack_e),
    .i2c_ena(ena), .i2c_addr(addr), .i2c_rw(rw), .i2c_wdata(wdata), .ack_err(ack_err),
    .clear_cnt(c_o), .red_cnt(r_o), .green_cnt(g_o), .blue_cnt(b_o));
  tb_i2c_model mdl (
    .clk(clk), .rst_n(rst_n), .ena(ena), .addr(addr), .rw(rw), .wdata(wdata), .nack(nack),
    .busy(busy), .rdata(rdata), .ack_error(ack_e), .evt(evt), .evt_rw(evt_rw),
    .evt_data(evt_data), .evt_addr(evt_addr));

  color_poll_seq #(.CLK_HZ(HZ), .GAIN(5), .ATIME(8'h3C)) dut_b (
    .clk(clk), .rst_n(rst_n), .i2c_busy(busy_b), .i2c_rdata(rdata_b), .i2c_ack_error(ack_b),
    .i2c_ena(ena_b), .i2c_addr(addr_b), .i2c_rw(rw_b), .i2c_wdata(wdata_b), .ack_err(ackerr_b),
    .clear_cnt(c_b), .red_cnt(r_b), .green_cnt(g_b), .blue_cnt(b_b));
  tb_i2c_model mdl_b (
    .clk(clk), .rst_n(rst_n), .ena(ena_b), .addr(addr_b), .rw(rw_b), .wdata(wdata_b), .nack(1'b0),
    .busy(busy_b), .rdata(rdata_b), .ack_error(ack_b), .evt(evt_b), .evt_rw(evt_rw_b),
    .evt_data(evt_data_b), .evt_addr(evt_addr_b));

  int errs = 0, checks = 0, poll = 0, rin = 0;
  ev_t expq[$];
  logic [63:0] cur_exp = '0;

  function automatic logic [7:0] pat(int n);
    return 8'(n * 37 + 5);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_init();
    expq.push_back('{0, 8'h8F, "R2"}); expq.push_back('{0, 8'h02, "R3"});
    expq.push_back('{0, 8'h81, "R2"}); expq.push_back('{0, 8'hC0, "R4"});
    expq.push_back('{0, 8'h80, "R2"}); expq.push_back('{0, 8'h03, "R2"});
  endtask

  task automatic push_polls(int n);
    for (int p = 0; p < n; p++) begin
      expq.push_back('{0, 8'hB4, "R5"});
      for (int i = 0; i < 8; i++) expq.push_back('{1, pat(8 * p + i), "R5"});
    end
  endtask

  function automatic logic [63:0] poll_vals(int p);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[63 - 8 * i -: 8] = pat(8 * p + (i ^ 1));
    return v;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // scoreboard monitor
  initial begin
    ev_t e;
    int k;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        poll = 0; rin = 0; cur_exp = '0;
      end else if (evt) begin
        chk(evt_addr == 7'h29, "R5 addr", 64'(evt_addr), 64'h29);
        if (expq.size() == 0) chk(0, "R2 unexpected byte", 64'(evt_data), 0);
        else begin
          e = expq.pop_front();
          chk(e.rw == evt_rw && e.d == evt_data, e.tag, {evt_rw, evt_data}, {e.rw, e.d});
        end
        if (evt_rw) begin
          rin++;
          if (rin == 8) begin
            chk({c_o, r_o, g_o, b_o} == cur_exp, "R7 hold", {c_o, r_o, g_o, b_o}, cur_exp);
            @(negedge clk);
            chk({c_o, r_o, g_o, b_o} == cur_exp, "R7 hold", {c_o, r_o, g_o, b_o}, cur_exp);
            @(negedge clk);
            cur_exp = poll_vals(poll);
            chk({c_o, r_o, g_o, b_o} == cur_exp, "R6 update", {c_o, r_o, g_o, b_o}, cur_exp);
            k = 0;
            do begin @(negedge clk); k++; end while (!ena && k < PAUSE + 20);
            chk(k == PAUSE, "R8 pause", 64'(k), 64'(PAUSE));
            rin = 0; poll++;
          end
        end
      end
    end
  end

  // second instance: fallback gain and raw integration byte
  initial begin
    int wb = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) wb = 0;
      else if (evt_b && !evt_rw_b) begin
        wb++;
        if (wb == 2) chk(evt_data_b == 8'h00, "R3 fallback", 64'(evt_data_b), 0);
        if (wb == 4) chk(evt_data_b == 8'h3C, "R4", 64'(evt_data_b), 64'h3C);
      end
    end
  end

  initial begin
    repeat (160000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int k;
    repeat (10) @(negedge clk);
    chk({c_o, r_o, g_o, b_o} == 0, "R10 reset outs", {c_o, r_o, g_o, b_o}, 0);
    chk(!ena && !ack_err, "R10 reset ctl", {ena, ack_err}, 0);
    push_init(); push_polls(3);
    rst_n = 1;
    k = 0;
    do begin @(negedge clk); k++; end while (!ena && k < UP + 20);
    chk(k == UP, "R1 powerup", 64'(k), 64'(UP));

    wait (poll == 1);
    @(negedge clk); nack = 1;
    @(negedge clk); chk(ack_err == 1, "R9 set", 64'(ack_err), 1);
    nack = 0;
    @(negedge clk); chk(ack_err == 0, "R9 clear", 64'(ack_err), 0);

    wait (poll == 2 && rin == 3);
    @(negedge clk); nack = 1;
    @(negedge clk); @(negedge clk);
    chk(ack_err == 1, "R9 set", 64'(ack_err), 1);
    chk({c_o, r_o, g_o, b_o} == poll_vals(1), "R6 before reset", {c_o, r_o, g_o, b_o}, poll_vals(1));
    rst_n = 0;
    #1;
    chk({c_o, r_o, g_o, b_o} == 0, "R10 async clear", {c_o, r_o, g_o, b_o}, 0);
    chk(!ena && !ack_err, "R10 async ctl", {ena, ack_err}, 0);
    nack = 0;
    expq.delete(); push_init(); push_polls(2);
    repeat (5) @(negedge clk);
    rst_n = 1;
    k = 0;
    do begin @(negedge clk); k++; end while (!ena && k < UP + 20);
    chk(k == UP, "R10 restart wait", 64'(k), 64'(UP));
    wait (poll == 2);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule